// File: doc/BRIEF.md
# RC Oscillator Frequency Meter

This block measures the frequency of an on-chip clock against the crystal clock so that software can trim an RC oscillator. The clock under test is chosen from three candidates: a 32 kHz clock, a fast RC clock and a slow RC clock. Software writes a window length, counted in cycles of the chosen clock, and then raises the start bit. While that window is open the block counts crystal cycles. When the window closes, the count goes into the result register and the start bit drops by itself.

The window is timed in the domain of the clock under test. The count is kept in the crystal domain. Two toggle handshakes link the two domains: one carries the start request and one carries the window-closed event. A gate level also crosses through a two-flop synchronizer, and the crystal side counts while that synchronized gate is high. The crystal cycles per window divided by the window length gives the ratio of the two frequencies.

Top module: `rc_freq_meter`

## Requirements
- R1: After reset, `start_busy`, `meas_done` and `result` are all zero.
- R2: `src_sel` selects the clock under test: 0 is `clk_32k`, 1 is `clk_frc`, 2 and 3 are `clk_src`.
- R3: A `start_set` pulse while idle with nonzero duration makes `start_busy` read 1 from the next crystal edge. The bit returns to 0 by itself in the same edge that loads `result`.
- R4: `result` is the number of crystal cycles during a window of `duration` cycles of the chosen clock, within plus or minus 2 of duration times the ratio of the two clock periods.
- R5: A start with `duration` equal to 0 completes at the next crystal edge. At that edge `meas_done` becomes 1, `result` becomes 0 and `start_busy` stays 0.
- R6: `src_sel` and `duration` are captured at the accepted start. Changes to them while `start_busy` is 1 do not affect the result.
- R7: `start_set` while `start_busy` is 1 has no effect. Busy stays 1, done stays 0, the running measurement is not restarted and `result` does not change until the load.
- R8: `meas_done` becomes 1 when `result` is loaded. It stays 1 until the next accepted start, which clears it.
- R9: The crystal count saturates at all ones of the `RES_W`-bit result and never wraps.
- R10: `start_busy` and `meas_done` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal reference clock, also the control domain |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| clk_32k | input | 1 | 32 kHz candidate clock |
| clk_frc | input | 1 | Fast RC candidate clock |
| clk_src | input | 1 | Slow RC candidate clock |
| src_sel | input | 2 | Clock-under-test select |
| duration | input | DUR_W (20) | Window length in cycles of the chosen clock |
| start_set | input | 1 | Request to set the start bit |
| start_busy | output | 1 | Start bit, cleared by hardware at completion |
| meas_done | output | 1 | Result-loaded flag |
| result | output | RES_W (24) | Crystal cycles counted during the window |

## Verification
The result load and a fresh start request can land in the same crystal cycle. In that cycle the start bit is clearing, and a start that arrives there must be ignored without disturbing the load. The bench provokes this by holding `start_set` high through an entire measurement. It then checks three things at the negedges around the busy fall. First, the first measurement's count appears with `meas_done` set for exactly one cycle. Second, the start is accepted only on the following edge. Third, that later start clears `meas_done` and sets busy again.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    SRC_32K  = 2'd0,
    SRC_FRC  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_ALT  = 2'd3
  } src_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/rfm_sync.sv
module rfm_sync #(
  parameter int STAGES = rfm_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rfm_clk_pick.sv
module rfm_clk_pick
  import rfm_pkg::*;
(
  input  logic clk_32k,
  input  logic clk_frc,
  input  logic clk_src,
  input  src_e pick,
  output logic clk_meas
);
  always_comb begin
    unique case (pick)
      SRC_32K:  clk_meas = clk_32k;
      SRC_FRC:  clk_meas = clk_frc;
      default:  clk_meas = clk_src;
    endcase
  end
endmodule

// File: rtl/rfm_window.sv
module rfm_window #(
  parameter int DUR_W = 20
) (
  input  logic             clk_meas,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  logic [DUR_W-1:0] dur,
  output logic             gate,
  output logic             fin_tgl
);
  logic             req_s;
  logic             req_seen;
  logic [DUR_W-1:0] cyc;
  logic             open_evt;
  logic             close_evt;

  rfm_sync u_req_sync (.clk(clk_meas), .rst_n(rst_n), .d_async(req_tgl), .q(req_s));

  assign open_evt  = (req_s != req_seen) && !gate;
  assign close_evt = gate && (cyc == dur);

  always_ff @(posedge clk_meas or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      gate     <= 1'b0;
      fin_tgl  <= 1'b0;
      cyc      <= '0;
    end else if (open_evt) begin
      req_seen <= req_s;
      gate     <= 1'b1;
      cyc      <= {{(DUR_W-1){1'b0}}, 1'b1};
    end else if (close_evt) begin
      gate    <= 1'b0;
      fin_tgl <= ~fin_tgl;
    end else if (gate) begin
      cyc <= cyc + 1'b1;
    end
  end
endmodule

// File: rtl/rc_freq_meter.sv
module rc_freq_meter
  import rfm_pkg::*;
#(
  parameter int DUR_W = 20,
  parameter int RES_W = 24
) (
  input  logic             clk_xtal,
  input  logic             rst_n,
  input  logic             clk_32k,
  input  logic             clk_frc,
  input  logic             clk_src,
  input  logic [1:0]       src_sel,
  input  logic [DUR_W-1:0] duration,
  input  logic             start_set,
  output logic             start_busy,
  output logic             meas_done,
  output logic [RES_W-1:0] result
);
  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  src_e             pick_q;
  logic [DUR_W-1:0] dur_q;
  logic             req_tgl;
  logic [RES_W-1:0] xcnt;
  logic             clk_meas;
  logic             gate;
  logic             fin_tgl;
  logic             gate_x;
  logic             fin_x;
  logic             fin_seen;

  // named events
  logic accept_evt;
  logic zero_evt;
  logic load_evt;

  assign accept_evt = start_set && !start_busy && (duration != '0);
  assign zero_evt   = start_set && !start_busy && (duration == '0);
  assign load_evt   = start_busy && (fin_x != fin_seen);

  rfm_clk_pick u_pick (
    .clk_32k(clk_32k), .clk_frc(clk_frc), .clk_src(clk_src),
    .pick(pick_q), .clk_meas(clk_meas)
  );

  rfm_window #(.DUR_W(DUR_W)) u_window (
    .clk_meas(clk_meas), .rst_n(rst_n), .req_tgl(req_tgl),
    .dur(dur_q), .gate(gate), .fin_tgl(fin_tgl)
  );

  rfm_sync u_gate_sync (.clk(clk_xtal), .rst_n(rst_n), .d_async(gate),    .q(gate_x));
  rfm_sync u_fin_sync  (.clk(clk_xtal), .rst_n(rst_n), .d_async(fin_tgl), .q(fin_x));

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      pick_q     <= SRC_32K;
      dur_q      <= '0;
      req_tgl    <= 1'b0;
      xcnt       <= '0;
      fin_seen   <= 1'b0;
      start_busy <= 1'b0;
      meas_done  <= 1'b0;
      result     <= '0;
    end else begin
      fin_seen <= fin_x;
      if (accept_evt) begin
        pick_q     <= src_e'(src_sel);
        dur_q      <= duration;
        req_tgl    <= ~req_tgl;
        xcnt       <= '0;
        start_busy <= 1'b1;
        meas_done  <= 1'b0;
      end else if (zero_evt) begin
        result    <= '0;
        meas_done <= 1'b1;
      end else if (load_evt) begin
        result     <= xcnt;
        start_busy <= 1'b0;
        meas_done  <= 1'b1;
      end else if (start_busy && gate_x) begin
        xcnt <= sat_inc(xcnt);
      end
    end
  end
endmodule

// File: rtl/rfm_checks.sv
module rfm_checks #(
  parameter int DUR_W = 20,
  parameter int RES_W = 24
) (
  input logic             clk_xtal,
  input logic             rst_n,
  input logic             start_set,
  input logic [DUR_W-1:0] duration,
  input logic             start_busy,
  input logic             meas_done,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] xcnt
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !(start_busy && meas_done));

  // R3
  busy_fall_loads_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $fell(start_busy) |-> meas_done);

  // R8
  done_hold_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (meas_done && !start_set) |=> meas_done);

  // R7
  result_frozen_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (start_busy && $past(start_busy)) |-> $stable(result));

  // R5
  zero_dur_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (start_set && !start_busy && duration == '0) |=> (meas_done && !start_busy && result == '0));

  // R9
  no_wrap_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (start_busy && $past(start_busy)) |-> (xcnt >= $past(xcnt)));
endmodule

bind rc_freq_meter rfm_checks #(.DUR_W(DUR_W), .RES_W(RES_W)) u_rfm_checks (
  .clk_xtal(clk_xtal), .rst_n(rst_n), .start_set(start_set), .duration(duration),
  .start_busy(start_busy), .meas_done(meas_done), .result(result), .xcnt(xcnt)
);

// File: tb/test_rc_freq_meter.sv
module test_rc_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int P32K = 90;
  localparam int PFRC = 16;
  localparam int PSLOW = 46;
  localparam int TOL = 2;

  logic clk_xtal = 0, clk_32k = 0, clk_frc = 0, clk_src = 0;
  logic rst_n = 0;
  logic [1:0]  src_sel = 0, s_src_sel = 0;
  logic [19:0] duration = 0, s_duration = 0;
  logic start_set = 0, s_start_set = 0;
  logic start_busy, meas_done, s_busy, s_done;
  logic [23:0] result;
  logic [7:0]  s_result;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;
  always #(P32K/2)  clk_32k = ~clk_32k;
  always #(PFRC/2)  clk_frc = ~clk_frc;
  always #(PSLOW/2) clk_src = ~clk_src;

  rc_freq_meter i_rc_freq_meter (
    .clk_xtal(clk_xtal), .rst_n(rst_n), .clk_32k(clk_32k), .clk_frc(clk_frc),
    .clk_src(clk_src), .src_sel(src_sel), .duration(duration), .start_set(start_set),
    .start_busy(start_busy), .meas_done(meas_done), .result(result)
  );

  rc_freq_meter #(.RES_W(8)) i_rc_freq_meter_sat (
    .clk_xtal(clk_xtal), .rst_n(rst_n), .clk_32k(clk_32k), .clk_frc(clk_frc),
    .clk_src(clk_src), .src_sel(s_src_sel), .duration(s_duration), .start_set(s_start_set),
    .start_busy(s_busy), .meas_done(s_done), .result(s_result)
  );

  function automatic int period_of(input logic [1:0] s);
    if (s == 2'd0) return P32K;
    if (s == 2'd1) return PFRC;
    return PSLOW;
  endfunction

  function automatic int expect_count(input logic [1:0] s, input int d, input int resw);
    longint e = (longint'(d) * period_of(s)) / CLK_PERIOD;
    longint cap = (longint'(1) << resw) - 1;
    return int'((e > cap) ? cap : e);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    chk((act >= exp - TOL) && (act <= exp + TOL), req, act, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 8000 && start_busy; i++) @(negedge clk_xtal);
  endtask

  // one measurement; optionally disturb inputs while running
  task automatic measure(input logic [1:0] s, input int d, input bit disturb, input string req);
    @(negedge clk_xtal);
    src_sel = s; duration = 20'(d); start_set = 1;
    @(negedge clk_xtal);
    start_set = 0;
    chk(start_busy == 1 && meas_done == 0, "R3", start_busy, 1);
    if (disturb) begin
      src_sel = s + 2'd1; duration = 20'(d + 37);
      @(negedge clk_xtal); start_set = 1;
      @(negedge clk_xtal); start_set = 0;
      // R7: stray start does not end or clear anything
      chk(start_busy == 1 && meas_done == 0, "R7", start_busy, 1);
    end
    wait_idle();
    chk(start_busy == 0 && meas_done == 1, "R8", meas_done, 1);
    near(req, int'(result), expect_count(s, d, 24));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_xtal);
    // R1 reset state
    chk(start_busy == 0 && meas_done == 0 && result == 0, "R1", result, 0);
    rst_n = 1;
    repeat (2) @(negedge clk_xtal);

    // R2 each source, directed
    measure(2'd0, 40, 0, "R2");
    measure(2'd1, 100, 0, "R2");
    measure(2'd2, 60, 0, "R2");
    measure(2'd3, 60, 0, "R2");
    // R4 single-cycle window
    measure(2'd2, 1, 0, "R4");

    // R5 zero duration
    @(negedge clk_xtal); duration = 0; start_set = 1;
    @(negedge clk_xtal); start_set = 0;
    chk(start_busy == 0 && meas_done == 1 && result == 0, "R5", result, 0);

    // R6 and R7 with disturbed inputs
    measure(2'd1, 80, 1, "R6");
    measure(2'd0, 30, 1, "R6");

    // random measurements, R4
    for (int k = 0; k < 20; k++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      int d = int'($urandom_range(1, 150));
      measure(s, d, (d > 20) && ($urandom_range(0, 1) == 1), "R4");
    end

    // collision: start held across the load cycle
    @(negedge clk_xtal); src_sel = 2'd1; duration = 20'd50; start_set = 1;
    @(negedge clk_xtal);
    chk(start_busy == 1, "R3", start_busy, 1);
    for (int i = 0; i < 8000 && start_busy; i++) @(negedge clk_xtal);
    chk(meas_done == 1 && start_busy == 0, "R8", meas_done, 1);
    near("R4", int'(result), expect_count(2'd1, 50, 24));
    @(negedge clk_xtal);
    start_set = 0;
    chk(start_busy == 1 && meas_done == 0, "R8", meas_done, 0);
    wait_idle();
    near("R4", int'(result), expect_count(2'd1, 50, 24));

    // R9 saturation on the narrow instance
    @(negedge clk_xtal); s_src_sel = 2'd0; s_duration = 20'd100; s_start_set = 1;
    @(negedge clk_xtal); s_start_set = 0;
    for (int i = 0; i < 8000 && s_busy; i++) @(negedge clk_xtal);
    chk(s_done == 1 && s_result == 8'hFF, "R9", s_result, 255);

    // R10 observed at the ports
    chk(!(start_busy && meas_done), "R10", start_busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_xtal) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule